// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing control logic of a 2048-byte serial EEPROM that sits on a two-wire (I2C-style) bus. The raw clock and data lines are brought into the fast system clock through a synchronizer. Clock edges and bus START/STOP conditions are found from the synchronized samples. A state machine then takes in the device header, the word address and the write bytes, and shifts out read bytes. The engine pulls SDA low only through an output enable and never drives it high. Each accepted write byte leaves the engine as a one-cycle write strobe with an 11-bit address. A one-cycle commit pulse follows STOP. A separate program controller owns the array, and its busy flag reports an internal program cycle.

The header holds a fixed 4-bit device type `1010` in bits 7:4, a 3-bit block select in bits 3:1 and a direction bit in bit 0, where 1 means read. Bits 10:8 of the 11-bit array address come from the block select of a write header, and bits 7:0 come from the word address byte. One internal pointer serves both directions. Writes advance it only inside the current 16-byte page. Reads advance all 11 bits. A write-protect input guards the upper half of the array.

States: `S_IDLE` (ignores the bus), `S_DEVADR` (header bits), `S_DEVACK` (header acknowledge), `S_WORDADR`, `S_WORDACK`, `S_WRDATA`, `S_WRACK`, `S_RDDATA` (driving a byte), `S_RDACK` (master acknowledge slot), `S_HOLD` (silent until the next START or STOP). Transitions:
- START from any state goes to `S_DEVADR`, and STOP from any state goes to `S_IDLE`.
- `S_DEVADR` goes to `S_DEVACK` on a match, or to `S_IDLE` on a mismatch or while busy.
- `S_DEVACK` goes to `S_RDDATA` for a read header or to `S_WORDADR` for a write header.
- `S_WORDADR` goes to `S_WORDACK`, which goes to `S_WRDATA`, which goes to `S_WRACK`.
- `S_WRACK` goes back to `S_WRDATA` after an acknowledge, or to `S_HOLD` after a protected NACK.
- `S_RDDATA` goes to `S_RDACK`, which goes back to `S_RDDATA` on a master ACK or to `S_HOLD` on a master NACK.

Top module: `eeprom_bus_engine`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START the engine drives nothing, even when a valid header is clocked in.
- R2: A header is acknowledged only when bits 7:4 equal `1010`. On a mismatch the engine stays released through all later bytes until a new START.
- R3: After a write header, the engine acknowledges the word address and each data byte. Each data byte emits `wr_valid` for one cycle, with `wr_addr` = {header bits 3:1, word address} plus the page offset and `wr_data` = the byte.
- R4: During a write, only address bits 3:0 advance. A page wraps within its 16 bytes, so a 17th byte overwrites the first address.
- R5: `commit` pulses for one cycle after a STOP only when at least one data byte was accepted since the previous STOP and none was refused by protection. It never pulses in the same cycle as `wr_valid`.
- R6: With `wp` high and an address at 0x400 or above, the header and word address are acknowledged. The data byte is NACKed, no `wr_valid` is emitted and no `commit` follows.
- R7: While `prog_busy` is high, a header of either direction is not acknowledged. Once busy drops, a header is acknowledged again.
- R8: Read bytes go out MSB first, and a 0 bit pulls SDA low. A master ACK (SDA low in the ninth clock) starts the next byte. A master NACK leaves SDA released until START or STOP.
- R9: A read header without a word address reads from the pointer, which holds the last accessed address plus one (0 after reset). The block bits of a read header are ignored.
- R10: A write header and a word address, followed by a repeated START and a read header, read from that word address.
- R11: Sequential reads advance all 11 pointer bits, and 0x7FF is followed by 0x000.
- R12: `sda_drive_low` is 0 after reset. It changes only in the cycle after a detected SCL fall, START or STOP.
- R13: A repeated START in the middle of a data byte discards that byte. No `wr_valid` is emitted for it, and header reception restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_drive_low | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| wp | input | 1 | Write protect for the upper half of the array |
| prog_busy | input | 1 | Program controller is in an internal program cycle |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 11 | Array address of the write byte |
| wr_data | output | 8 | Write byte |
| commit | output | 1 | One-cycle request to start the program cycle |
| rd_addr | output | 11 | Current pointer, used as the array read address |
| rd_data | input | 8 | Array contents at `rd_addr` |

## Verification
The directed patterns isolate one rule each:
- a header clocked before any START, and a foreign device type, show that the engine stays silent;
- a 6-byte write that crosses a page end, and an 18-byte overflow, separate page wrap from full-address increment;
- a 4-byte read across 0x7FF separates the full-address increment from page wrap;
- a write to the protected upper half, with a matching one to the lower half, separates protection from ordinary writes;
- headers sent while busy show the polling NACK;
- a START three bits into a data byte shows that the partial byte is dropped.

Random page writes, random reads and current-address reads follow, with random `wp`, addresses and lengths, all checked against a bench model of the array and pointer.

// File: rtl/eeprom_bus_pkg.sv
`timescale 1ns/1ps
package eeprom_bus_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADR,
        S_DEVACK,
        S_WORDADR,
        S_WORDACK,
        S_WRDATA,
        S_WRACK,
        S_RDDATA,
        S_RDACK,
        S_HOLD
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
    localparam int         BYTE_W        = 8;

endpackage

// File: rtl/bus_line_sync.sv
`timescale 1ns/1ps
module bus_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bus_cond_detect.sv
`timescale 1ns/1ps
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_evt = scl & scl_d & sda_d & ~sda;
    assign stop_evt  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/word_addr_ctr.sv
`timescale 1ns/1ps
module word_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_all,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [PAGE_W-1:0] ONE_P = 1;

    logic [PAGE_W-1:0] low_next;
    assign low_next = addr[PAGE_W-1:0] + ONE_P;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         addr <= '0;
        else if (load)      addr <= load_val;
        else if (step_all)  addr <= addr + ONE_A;
        else if (step_page) addr <= {addr[ADDR_W-1:PAGE_W], low_next};
    end
endmodule

// File: rtl/eeprom_bus_engine.sv
`timescale 1ns/1ps
module eeprom_bus_engine
    import eeprom_bus_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int BLK_W       = 3,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic              wp,
    input  logic              prog_busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int        WORD_W   = ADDR_W - BLK_W;
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    // synchronized lines and bus events
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    bus_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_in, sda_in}),
        .q       (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    bus_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // address pointer
    logic              ctr_load, ctr_step_page, ctr_step_all;
    logic [ADDR_W-1:0] ctr_load_val, ctr_addr;

    word_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_val  (ctr_load_val),
        .step_page (ctr_step_page),
        .step_all  (ctr_step_all),
        .addr      (ctr_addr)
    );
    assign rd_addr = ctr_addr;

    // control state
    eng_state_t       state_q, state_d;
    logic [2:0]       bit_q, bit_d;
    logic [7:0]       sh_q, sh_d;
    logic [7:0]       tx_q, tx_d;
    logic [1:0]       phase_q, phase_d;
    logic             ack_q, ack_d;
    logic             rw_q, rw_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    logic             wr_any_q, wr_any_d;
    logic             wp_hit_q, wp_hit_d;

    // output registers
    logic              oe_q, oe_d;
    logic              wr_valid_d, commit_d;
    logic [ADDR_W-1:0] wr_addr_d;
    logic [7:0]        wr_data_d;

    logic [7:0] byte_in;
    logic       last_rise;
    assign byte_in   = {sh_q[6:0], sda_s};
    assign last_rise = scl_rise && (bit_q == LAST_BIT);

    always_comb begin
        state_d       = state_q;
        bit_d         = bit_q;
        sh_d          = sh_q;
        tx_d          = tx_q;
        phase_d       = phase_q;
        ack_d         = ack_q;
        rw_d          = rw_q;
        blk_d         = blk_q;
        wr_any_d      = wr_any_q;
        wp_hit_d      = wp_hit_q;
        oe_d          = oe_q;
        wr_valid_d    = 1'b0;
        commit_d      = 1'b0;
        wr_addr_d     = wr_addr;
        wr_data_d     = wr_data;
        ctr_load      = 1'b0;
        ctr_load_val  = {blk_q, byte_in[WORD_W-1:0]};
        ctr_step_page = 1'b0;
        ctr_step_all  = 1'b0;

        if (start_evt) begin
            state_d = S_DEVADR;
            bit_d   = '0;
            phase_d = '0;
            oe_d    = 1'b0;
        end else if (stop_evt) begin
            state_d  = S_IDLE;
            oe_d     = 1'b0;
            commit_d = wr_any_q && !wp_hit_q;
            wr_any_d = 1'b0;
            wp_hit_d = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_HOLD: begin
                    oe_d = 1'b0;
                end

                S_DEVADR: begin
                    if (scl_rise) begin
                        sh_d  = byte_in;
                        bit_d = bit_q + 3'd1;
                        if (last_rise) begin
                            bit_d   = '0;
                            phase_d = '0;
                            if (byte_in[7:4] == DEV_TYPE_CODE && !prog_busy) begin
                                rw_d    = byte_in[0];
                                ack_d   = 1'b1;
                                state_d = S_DEVACK;
                                if (!byte_in[0]) blk_d = byte_in[BLK_W:1];
                            end else begin
                                state_d = S_IDLE;
                            end
                        end
                    end
                end

                S_WORDADR: begin
                    if (scl_rise) begin
                        sh_d  = byte_in;
                        bit_d = bit_q + 3'd1;
                        if (last_rise) begin
                            bit_d    = '0;
                            phase_d  = '0;
                            ctr_load = 1'b1;
                            ack_d    = 1'b1;
                            state_d  = S_WORDACK;
                        end
                    end
                end

                S_WRDATA: begin
                    if (scl_rise) begin
                        sh_d  = byte_in;
                        bit_d = bit_q + 3'd1;
                        if (last_rise) begin
                            bit_d   = '0;
                            phase_d = '0;
                            state_d = S_WRACK;
                            if (wp && ctr_addr[ADDR_W-1]) begin
                                ack_d    = 1'b0;
                                wp_hit_d = 1'b1;
                            end else begin
                                ack_d         = 1'b1;
                                wr_valid_d    = 1'b1;
                                wr_addr_d     = ctr_addr;
                                wr_data_d     = byte_in;
                                ctr_step_page = 1'b1;
                                wr_any_d      = 1'b1;
                            end
                        end
                    end
                end

                S_DEVACK, S_WORDACK, S_WRACK: begin
                    if (scl_fall) begin
                        if (phase_q == 2'd0) begin
                            oe_d    = ack_q;
                            phase_d = 2'd1;
                        end else begin
                            oe_d    = 1'b0;
                            phase_d = 2'd0;
                            bit_d   = '0;
                            if (state_q == S_DEVACK) begin
                                if (rw_q) begin
                                    state_d = S_RDDATA;
                                    tx_d    = rd_data;
                                    oe_d    = !rd_data[7];
                                end else begin
                                    state_d = S_WORDADR;
                                end
                            end else if (state_q == S_WORDACK) begin
                                state_d = S_WRDATA;
                            end else begin
                                state_d = ack_q ? S_WRDATA : S_HOLD;
                            end
                        end
                    end
                end

                S_RDDATA: begin
                    if (scl_rise) begin
                        bit_d = bit_q + 3'd1;
                        if (last_rise) begin
                            bit_d        = '0;
                            phase_d      = '0;
                            ctr_step_all = 1'b1;
                            state_d      = S_RDACK;
                        end
                    end else if (scl_fall) begin
                        tx_d = {tx_q[6:0], 1'b0};
                        oe_d = !tx_q[6];
                    end
                end

                S_RDACK: begin
                    if (phase_q == 2'd0) begin
                        if (scl_fall) begin
                            oe_d    = 1'b0;
                            phase_d = 2'd1;
                        end
                    end else if (phase_q == 2'd1) begin
                        if (scl_rise) begin
                            if (!sda_s) phase_d = 2'd2;
                            else        state_d = S_HOLD;
                        end
                    end else begin
                        if (scl_fall) begin
                            tx_d    = rd_data;
                            oe_d    = !rd_data[7];
                            bit_d   = '0;
                            phase_d = 2'd0;
                            state_d = S_RDDATA;
                        end
                    end
                end

                default: begin
                    state_d = S_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            bit_q    <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            phase_q  <= '0;
            ack_q    <= 1'b0;
            rw_q     <= 1'b0;
            blk_q    <= '0;
            wr_any_q <= 1'b0;
            wp_hit_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            bit_q    <= bit_d;
            sh_q     <= sh_d;
            tx_q     <= tx_d;
            phase_q  <= phase_d;
            ack_q    <= ack_d;
            rw_q     <= rw_d;
            blk_q    <= blk_d;
            wr_any_q <= wr_any_d;
            wp_hit_q <= wp_hit_d;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q     <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            commit   <= 1'b0;
        end else begin
            oe_q     <= oe_d;
            wr_valid <= wr_valid_d;
            wr_addr  <= wr_addr_d;
            wr_data  <= wr_data_d;
            commit   <= commit_d;
        end
    end

    assign sda_drive_low = oe_q;
endmodule

// File: rtl/eeprom_bus_checker.sv
`timescale 1ns/1ps
module eeprom_bus_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              sda_drive_low,
    input logic              wp,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              commit
);
    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_evt)); // R5

    AST_WR_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && wr_valid)); // R5

    AST_WP_NO_UPPER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wp)) |-> !wr_addr[ADDR_W-1]); // R6

    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(scl_rise)); // R3

    AST_SDA_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> $past(scl_fall || start_evt || stop_evt)); // R12
endmodule

bind eeprom_bus_engine eeprom_bus_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .sda_drive_low (sda_drive_low),
    .wp            (wp),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .commit        (commit)
);

// File: tb/tb_eeprom_bus_engine.sv
`timescale 1ns/1ps
module tb_eeprom_bus_engine;
    localparam int Q        = 8;
    localparam int BUSY_CYC = 1500;
    localparam int MEM_N    = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_drive_low, wp = 1'b0, prog_busy;
    logic        wr_valid, commit;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_drive_low;

    eeprom_bus_engine dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .wp(wp), .prog_busy(prog_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // program controller and array model
    logic [7:0] mem     [MEM_N];
    logic [7:0] pend    [MEM_N];
    logic       pend_v  [MEM_N];
    logic [7:0] exp_mem [MEM_N];
    logic [10:0] exp_ptr;
    int n_wr = 0, n_commit = 0, busy_cnt = 0;
    int total = 0, bad = 0;
    bit done = 0;

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] hdr(input logic [2:0] b, input logic r);
        return {4'b1010, b, r};
    endfunction

    assign rd_data   = mem[rd_addr];
    assign prog_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) begin
                mem[i]    <= init_val(i);
                pend_v[i] <= 1'b0;
            end
        end else begin
            if (wr_valid) begin
                pend[wr_addr]   <= wr_data;
                pend_v[wr_addr] <= 1'b1;
                n_wr            <= n_wr + 1;
            end
            if (commit) begin
                for (int i = 0; i < MEM_N; i++) begin
                    if (pend_v[i]) mem[i] <= pend[i];
                    pend_v[i] <= 1'b0;
                end
                n_commit <= n_commit + 1;
                busy_cnt <= BUSY_CYC;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        tick(Q); m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; tick(2*Q); m_scl = 1'b1; tick(Q); b = sda_line; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        ack = !a;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(!mack);
    endtask

    task automatic wait_ready();
        while (prog_busy) tick(1);
        tick(20);
    endtask

    task automatic do_write(input logic [10:0] a, input int n);
        logic ak;
        logic [7:0] d;
        int c0, w0;
        logic prot;
        c0 = n_commit; w0 = n_wr; prot = wp && a[10];
        bus_start();
        send_byte(hdr(a[10:8], 1'b0), ak); chk(ak == 1'b1, "R2 write header ack", ak, 1);
        send_byte(a[7:0], ak);             chk(ak == 1'b1, "R3 word address ack", ak, 1);
        if (prot) begin
            d = 8'($urandom);
            send_byte(d, ak); chk(ak == 1'b0, "R6 protected data nack", ak, 0);
        end else begin
            for (int i = 0; i < n; i++) begin
                d = 8'($urandom);
                send_byte(d, ak);
                chk(ak == 1'b1, (i >= 16) ? "R4 overflow byte ack" : "R3 data ack", ak, 1);
                exp_mem[{a[10:4], 4'(a[3:0] + 4'(i))}] = d;
            end
        end
        bus_stop(); tick(4);
        if (prot) begin
            chk(n_commit == c0, "R6 no commit when protected", n_commit - c0, 0);
            chk(n_wr == w0, "R6 no write strobe when protected", n_wr - w0, 0);
            exp_ptr = a;
        end else begin
            chk(n_commit == c0 + 1, "R5 one commit after stop", n_commit - c0, 1);
            chk(n_wr == w0 + n, "R3 write strobe count", n_wr - w0, n);
            exp_ptr = {a[10:4], 4'(a[3:0] + 4'(n))};
        end
    endtask

    task automatic do_read(input logic rnd, input logic [10:0] a, input int n, input string req);
        logic ak;
        logic [7:0] d;
        if (rnd) begin
            bus_start();
            send_byte(hdr(a[10:8], 1'b0), ak); chk(ak == 1'b1, "R10 dummy header ack", ak, 1);
            send_byte(a[7:0], ak);             chk(ak == 1'b1, "R10 dummy word ack", ak, 1);
            exp_ptr = a;
        end
        bus_start();
        send_byte(hdr(3'($urandom), 1'b1), ak); chk(ak == 1'b1, "R2 read header ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 11'd1;
        end
        bus_stop(); tick(4);
    endtask

    initial begin
        logic ak;
        logic [7:0] d;
        int c0, w0;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_N; i++) exp_mem[i] = init_val(i);
        exp_ptr = '0;
        tick(10);
        chk(sda_drive_low == 1'b0, "R12 released in reset", sda_drive_low, 0);
        rst_n = 1'b1;
        tick(10);
        chk(sda_drive_low == 1'b0 && commit == 1'b0 && wr_valid == 1'b0,
            "R5 quiet after reset", {sda_drive_low, commit, wr_valid}, 0);

        // R1: a header with no START before it
        send_byte(hdr(3'd0, 1'b0), ak);
        chk(ak == 1'b0, "R1 no ack before START", ak, 0);
        bus_stop();

        // R9: current address read after reset starts at 0
        do_read(1'b0, 11'd0, 2, "R9 current read after reset");

        // R2: foreign device type stays silent
        bus_start();
        send_byte(8'h92, ak); chk(ak == 1'b0, "R2 mismatch nack", ak, 0);
        send_byte(8'h00, ak); chk(ak == 1'b0, "R2 released after mismatch", ak, 0);
        bus_stop();

        // R4: page wrap, then R9 pointer after the write
        do_write(11'h21C, 6);
        wait_ready();
        do_read(1'b0, 11'd0, 1, "R9 current read after page write");
        do_read(1'b1, 11'h210, 16, "R4 page contents after wrap");

        // R4: overflow beyond 16 bytes
        do_write(11'h130, 18);
        wait_ready();
        do_read(1'b1, 11'h130, 16, "R4 overflow contents");

        // R7: polling while busy
        do_write(11'h0A0, 2);
        c0 = n_commit;
        bus_start();
        send_byte(hdr(3'd0, 1'b0), ak); chk(ak == 1'b0, "R7 busy write header nack", ak, 0);
        bus_start();
        send_byte(hdr(3'd0, 1'b1), ak); chk(ak == 1'b0, "R7 busy read header nack", ak, 0);
        bus_stop();
        wait_ready();
        bus_start();
        send_byte(hdr(3'd0, 1'b0), ak); chk(ak == 1'b1, "R7 ack once idle", ak, 1);
        bus_stop(); tick(4);
        chk(n_commit == c0, "R5 no commit without data", n_commit - c0, 0);

        // R6: protected upper half, then lower half still writable
        wp = 1'b1;
        do_write(11'h5A0, 3);
        do_read(1'b1, 11'h5A0, 3, "R6 protected bytes unchanged");
        do_write(11'h0F0, 3);
        wait_ready();
        do_read(1'b1, 11'h0F0, 3, "R6 lower half written under protect");
        wp = 1'b0;

        // R11: wrap of the full address during sequential read
        do_read(1'b1, 11'h7FE, 4, "R11 sequential wrap");

        // R8: released after master NACK
        do_read(1'b1, 11'h100, 1, "R8 single read");
        bus_start();
        send_byte(hdr(3'd1, 1'b1), ak); chk(ak == 1'b1, "R8 header ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d == exp_mem[exp_ptr], "R8 byte before nack", d, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 11'd1;
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R8 line released after master nack", d, 8'hFF);
        bus_stop(); tick(4);

        // R13: repeated START in the middle of a data byte
        w0 = n_wr; c0 = n_commit;
        bus_start();
        send_byte(hdr(3'd3, 1'b0), ak); chk(ak == 1'b1, "R13 header ack", ak, 1);
        send_byte(8'h40, ak);           chk(ak == 1'b1, "R13 word ack", ak, 1);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        exp_ptr = 11'h340;
        bus_start();
        send_byte(hdr(3'd6, 1'b1), ak); chk(ak == 1'b1, "R13 restart header ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d == exp_mem[11'h340], "R13 read after dropped byte", d, exp_mem[11'h340]);
        exp_ptr = exp_ptr + 11'd1;
        bus_stop(); tick(4);
        chk(n_wr == w0, "R13 partial byte not written", n_wr - w0, 0);
        chk(n_commit == c0, "R13 no commit", n_commit - c0, 0);

        // random mix
        for (int it = 0; it < 10; it++) begin
            logic [10:0] a;
            int op;
            a  = 11'($urandom);
            op = int'($urandom % 3);
            if (op == 0) begin
                wp = 1'($urandom);
                do_write(a, 1 + int'($urandom % 12));
                wait_ready();
                wp = 1'b0;
            end else if (op == 1) begin
                do_read(1'b1, a, 1 + int'($urandom % 6), "R10 random read");
            end else begin
                do_read(1'b0, 11'd0, 1 + int'($urandom % 4), "R9 current read");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule